// File: doc/BRIEF.md
# Valid-Bit Release Command Ring Consumer

This block is the hardware end of an eight-slot release-command ring. Software fills a slot with a release command: an 8-bit verb (an in-band valid bit, a 3-bit command and a 4-bit buffer count), a pool identifier and up to eight buffer addresses, each with its own pool identifier. In valid-bit producer mode the block finds new slots by comparing each slot's valid bit with an expected polarity that flips every time the producer index wraps. No producer index is written by software in that mode. In the two index producer modes, software writes the producer index directly and the valid bit carries no meaning.

Each recognised slot is decoded into a per-lane buffer list. Every lane gets a buffer address and the pool identifier that applies to it. The list is offered to a downstream buffer sink with a valid/ready handshake, and the consumer index advances one slot per accepted entry. Slots with malformed verbs are discarded and flagged. Both ring indices can be read, each with a wrap (phase) bit, together with the fill level and the free space. A programmable threshold raises a sticky interrupt as the ring drains.

Top module: `rcr_vb_consumer`

## Requirements
- R1: After reset the producer and consumer indices are 0, fill is 0, free is 7, and snk_valid, irq and cmd_err are all 0. Every stored verb resets to 0.
- R2: When cfg_mode is 2 (valid-bit mode), the slot at the producer index counts as new when its verb bit 7 equals the expected polarity. The expected polarity is 1 while producer index bit 3 is 0, and 0 while it is 1. A slot written in cycle N advances the producer index by one at the clock edge that ends cycle N+1. A slot whose bit 7 has the other polarity leaves the index unchanged.
- R3: The index outputs carry the slot number in bits 2:0 and a phase bit in bit 3 that toggles when the slot number wraps from 7 to 0. fill equals (producer − consumer) mod 16, and free equals 7 − fill, limited at 0.
- R4: In valid-bit mode the producer index never advances while fill is 7. A new slot waiting behind a full ring is picked up once an entry has been consumed.
- R5: snk_valid is high when fill is non-zero and the verb at the consumer slot is legal. The consumer index advances by exactly one at each edge where snk_valid and snk_ready are both high, and holds while snk_ready is low. Entries leave in ring order.
- R6: Command code 2 (verb bits 6:4) gives every lane below the count (verb bits 3:0) the entry's shared pool identifier. Lanes at or above the count output zero address and zero pool.
- R7: Command code 3 gives every lane below the count its own per-buffer pool identifier together with its address.
- R8: A pending verb is illegal when its command is neither 2 nor 3, or its count is 0 or greater than 8. An illegal entry is never offered to the sink. It is consumed at the next edge whatever snk_ready is, and it sets cmd_err, which stays set until reset.
- R9: When cfg_mode is not 2, the producer index loads pi_wdata at each edge where pi_we is high, and valid bits are ignored. In valid-bit mode pi_we has no effect.
- R10: At every consumption (delivered or dropped), irq is set if the remaining fill (fill − 1) is at most ithresh. It stays set until an edge where irq_clr is high and no new set occurs. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Producer mode: 0/1 index written by software, 2 valid-bit |
| ent_we | input | 1 | Write one ring slot |
| ent_slot | input | 3 | Slot number written |
| ent_verb | input | 8 | Verb: bit 7 valid, 6:4 command, 3:0 count |
| ent_pool | input | 6 | Shared pool identifier |
| ent_addr | input | 128 | Eight 16-bit buffer addresses, lane 0 in the low bits |
| ent_bpid | input | 48 | Eight 6-bit per-buffer pool identifiers |
| pi_we | input | 1 | Producer index write (index modes only) |
| pi_wdata | input | 4 | Producer index value with phase bit |
| ithresh | input | 4 | Interrupt fill threshold |
| irq_clr | input | 1 | Clear interrupt status |
| snk_ready | input | 1 | Sink accepts the offered entry |
| snk_valid | output | 1 | Decoded entry offered |
| snk_count | output | 4 | Number of buffers in the entry |
| snk_addr | output | 128 | Per-lane buffer addresses, unused lanes zero |
| snk_pool | output | 48 | Per-lane pool identifiers, unused lanes zero |
| pi_idx | output | 4 | Producer index with phase bit |
| ci_idx | output | 4 | Consumer index with phase bit |
| fill | output | 4 | Outstanding entries |
| free | output | 4 | Free slots |
| irq | output | 1 | Ring threshold interrupt status |
| cmd_err | output | 1 | Sticky malformed-command flag |

## Verification
The bench rewrites a slot with the stale polarity first and then the correct one. A design that ignores or inverts the polarity would advance on the stale write. It fills the ring with eight valid slots across a wrap, so a design with no fill cap would overrun to fill 8 and an off-by-one phase would stall after slot 7. Entries with a bad command, a zero count and a count of nine are sent while the sink is ready, so a design that forwards them would trip the scoreboard and one that waits for ready would stall the consumer index. The threshold is approached one consumption at a time, and clear and set are made to collide in the same cycle, which catches an off-by-one comparison or a clear that takes priority over a set.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int VERB_W   = 8;
    localparam int CMD_W    = 3;
    localparam int CNT_W    = 4;
    localparam int VBIT_POS = 7;

    typedef enum logic [1:0] {
        PM_IDX_UNCACHED = 2'd0,
        PM_IDX_CACHED   = 2'd1,
        PM_VALID_BIT    = 2'd2,
        PM_RESERVED     = 2'd3
    } prod_mode_e;

    localparam logic [CMD_W-1:0] CMD_ONE_POOL = 3'h2;
    localparam logic [CMD_W-1:0] CMD_PER_BUF  = 3'h3;
endpackage

// File: rtl/rcr_slot_store.sv
module rcr_slot_store
    import rcr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NBUF   = 8,
    parameter int ADDR_W = 16,
    parameter int POOL_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [IDX_W-1:0]         slot_i,
    input  logic [VERB_W-1:0]        verb_i,
    input  logic [POOL_W-1:0]        pool_i,
    input  logic [NBUF*ADDR_W-1:0]   addr_i,
    input  logic [NBUF*POOL_W-1:0]   bpid_i,
    input  logic [IDX_W-1:0]         scan_idx_i,
    output logic                     scan_vbit_o,
    input  logic [IDX_W-1:0]         rd_idx_i,
    output logic [VERB_W-2:0]        rd_cmdcnt_o,
    output logic [POOL_W-1:0]        rd_pool_o,
    output logic [NBUF*ADDR_W-1:0]   rd_addr_o,
    output logic [NBUF*POOL_W-1:0]   rd_bpid_o
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [VERB_W-1:0]      verb;
        logic [POOL_W-1:0]      pool;
        logic [NBUF*ADDR_W-1:0] addr;
        logic [NBUF*POOL_W-1:0] bpid;
    } slot_t;

    slot_t ring_d [DEPTH];
    slot_t ring_q [DEPTH];

    always_comb begin
        ring_d = ring_q;
        if (we_i) begin
            ring_d[slot_i].verb = verb_i;
            ring_d[slot_i].pool = pool_i;
            ring_d[slot_i].addr = addr_i;
            ring_d[slot_i].bpid = bpid_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                ring_q[k] <= '0;
            end
        end else begin
            ring_q <= ring_d;
        end
    end

    assign scan_vbit_o = ring_q[scan_idx_i].verb[VBIT_POS];
    assign rd_cmdcnt_o = ring_q[rd_idx_i].verb[VERB_W-2:0];
    assign rd_pool_o   = ring_q[rd_idx_i].pool;
    assign rd_addr_o   = ring_q[rd_idx_i].addr;
    assign rd_bpid_o   = ring_q[rd_idx_i].bpid;
endmodule

// File: rtl/rcr_prod_track.sv
module rcr_prod_track
    import rcr_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             scan_vbit_i,
    input  logic [IDX_W:0]   ci_i,
    input  logic             pi_we_i,
    input  logic [IDX_W:0]   pi_wdata_i,
    output logic [IDX_W:0]   pi_o,
    output logic [IDX_W-1:0] scan_idx_o
);
    localparam int PTR_W = IDX_W + 1;
    localparam logic [PTR_W-1:0] CAP = PTR_W'((1 << IDX_W) - 1);

    typedef struct packed {
        logic [PTR_W-1:0] pi;
    } prod_st_t;

    prod_st_t st_d, st_q;
    logic vb_mode, expect_vbit, seen;
    logic [PTR_W-1:0] fill;

    always_comb begin
        st_d        = st_q;
        vb_mode     = (prod_mode_e'(mode_i) == PM_VALID_BIT);
        fill        = st_q.pi - ci_i;
        // polarity expected on the current lap: 1 on even laps, 0 on odd
        expect_vbit = ~st_q.pi[IDX_W];
        seen        = (scan_vbit_i == expect_vbit) && (fill < CAP);
        if (vb_mode) begin
            if (seen) begin
                st_d.pi = st_q.pi + PTR_W'(1);
            end
        end else if (pi_we_i) begin
            st_d.pi = pi_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pi_o       = st_q.pi;
    assign scan_idx_o = st_q.pi[IDX_W-1:0];

    // R2
    pi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_mode_e'(mode_i) == PM_VALID_BIT) |=>
            (st_q.pi == $past(st_q.pi) || st_q.pi == $past(st_q.pi) + PTR_W'(1)));

    // R4
    fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_mode && fill <= CAP) |=> ((st_q.pi - ci_i) <= CAP));
endmodule

// File: rtl/rcr_cons_decode.sv
module rcr_cons_decode
    import rcr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NBUF   = 8,
    parameter int ADDR_W = 16,
    parameter int POOL_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W:0]         pi_i,
    input  logic [VERB_W-2:0]      cmdcnt_i,
    input  logic [POOL_W-1:0]      pool_i,
    input  logic [NBUF*ADDR_W-1:0] addr_i,
    input  logic [NBUF*POOL_W-1:0] bpid_i,
    input  logic                   snk_ready_i,
    input  logic [IDX_W:0]         ithresh_i,
    input  logic                   irq_clr_i,
    output logic [IDX_W:0]         ci_o,
    output logic                   snk_valid_o,
    output logic [CNT_W-1:0]       snk_count_o,
    output logic [NBUF*ADDR_W-1:0] snk_addr_o,
    output logic [NBUF*POOL_W-1:0] snk_pool_o,
    output logic                   irq_o,
    output logic                   err_o
);
    localparam int PTR_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NBUF);

    typedef struct packed {
        logic [PTR_W-1:0] ci;
        logic             irq;
        logic             err;
    } cons_st_t;

    cons_st_t st_d, st_q;
    logic [CMD_W-1:0] cmd;
    logic [CNT_W-1:0] cnt;
    logic pending, legal, offer, drop, take;
    logic [PTR_W-1:0] remain;

    assign cmd = cmdcnt_i[CNT_W +: CMD_W];
    assign cnt = cmdcnt_i[CNT_W-1:0];

    always_comb begin
        st_d    = st_q;
        pending = (pi_i != st_q.ci);
        legal   = ((cmd == CMD_ONE_POOL) || (cmd == CMD_PER_BUF)) &&
                  (cnt != '0) && (cnt <= MAX_CNT);
        offer   = pending && legal;
        drop    = pending && !legal;
        take    = (offer && snk_ready_i) || drop;
        remain  = pi_i - st_q.ci - PTR_W'(1);
        if (take) begin
            st_d.ci = st_q.ci + PTR_W'(1);
        end
        if (drop) begin
            st_d.err = 1'b1;
        end
        if (take && (remain <= ithresh_i)) begin
            st_d.irq = 1'b1;
        end else if (irq_clr_i) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_lane
        logic on;
        assign on = (cnt > CNT_W'(g));
        assign snk_addr_o[g*ADDR_W +: ADDR_W] = on ? addr_i[g*ADDR_W +: ADDR_W] : '0;
        assign snk_pool_o[g*POOL_W +: POOL_W] = !on ? '0 :
            (cmd == CMD_ONE_POOL) ? pool_i : bpid_i[g*POOL_W +: POOL_W];
    end

    assign ci_o        = st_q.ci;
    assign snk_valid_o = offer;
    assign snk_count_o = cnt;
    assign irq_o       = st_q.irq;
    assign err_o       = st_q.err;

    // R5
    ci_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid_o && !snk_ready_i) |=> $stable(st_q.ci));

    // R3
    ci_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid_o && snk_ready_i && (st_q.ci[IDX_W-1:0] == '1)) |=>
            ((st_q.ci[IDX_W-1:0] == '0) && (st_q.ci[IDX_W] != $past(st_q.ci[IDX_W]))));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_clr_i) |=> st_q.irq);
endmodule

// File: rtl/rcr_vb_consumer.sv
module rcr_vb_consumer
    import rcr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NBUF   = 8,
    parameter int ADDR_W = 16,
    parameter int POOL_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cfg_mode,
    input  logic                   ent_we,
    input  logic [IDX_W-1:0]       ent_slot,
    input  logic [VERB_W-1:0]      ent_verb,
    input  logic [POOL_W-1:0]      ent_pool,
    input  logic [NBUF*ADDR_W-1:0] ent_addr,
    input  logic [NBUF*POOL_W-1:0] ent_bpid,
    input  logic                   pi_we,
    input  logic [IDX_W:0]         pi_wdata,
    input  logic [IDX_W:0]         ithresh,
    input  logic                   irq_clr,
    input  logic                   snk_ready,
    output logic                   snk_valid,
    output logic [CNT_W-1:0]       snk_count,
    output logic [NBUF*ADDR_W-1:0] snk_addr,
    output logic [NBUF*POOL_W-1:0] snk_pool,
    output logic [IDX_W:0]         pi_idx,
    output logic [IDX_W:0]         ci_idx,
    output logic [IDX_W:0]         fill,
    output logic [IDX_W:0]         free,
    output logic                   irq,
    output logic                   cmd_err
);
    localparam int PTR_W = IDX_W + 1;
    localparam logic [PTR_W-1:0] CAP = PTR_W'((1 << IDX_W) - 1);

    logic                   scan_vbit;
    logic [IDX_W-1:0]       scan_idx;
    logic [VERB_W-2:0]      rd_cmdcnt;
    logic [POOL_W-1:0]      rd_pool;
    logic [NBUF*ADDR_W-1:0] rd_addr;
    logic [NBUF*POOL_W-1:0] rd_bpid;

    rcr_slot_store #(
        .IDX_W(IDX_W), .NBUF(NBUF), .ADDR_W(ADDR_W), .POOL_W(POOL_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (ent_we),
        .slot_i      (ent_slot),
        .verb_i      (ent_verb),
        .pool_i      (ent_pool),
        .addr_i      (ent_addr),
        .bpid_i      (ent_bpid),
        .scan_idx_i  (scan_idx),
        .scan_vbit_o (scan_vbit),
        .rd_idx_i    (ci_idx[IDX_W-1:0]),
        .rd_cmdcnt_o (rd_cmdcnt),
        .rd_pool_o   (rd_pool),
        .rd_addr_o   (rd_addr),
        .rd_bpid_o   (rd_bpid)
    );

    rcr_prod_track #(
        .IDX_W(IDX_W)
    ) u_prod (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (cfg_mode),
        .scan_vbit_i (scan_vbit),
        .ci_i        (ci_idx),
        .pi_we_i     (pi_we),
        .pi_wdata_i  (pi_wdata),
        .pi_o        (pi_idx),
        .scan_idx_o  (scan_idx)
    );

    rcr_cons_decode #(
        .IDX_W(IDX_W), .NBUF(NBUF), .ADDR_W(ADDR_W), .POOL_W(POOL_W)
    ) u_cons (
        .clk         (clk),
        .rst_n       (rst_n),
        .pi_i        (pi_idx),
        .cmdcnt_i    (rd_cmdcnt),
        .pool_i      (rd_pool),
        .addr_i      (rd_addr),
        .bpid_i      (rd_bpid),
        .snk_ready_i (snk_ready),
        .ithresh_i   (ithresh),
        .irq_clr_i   (irq_clr),
        .ci_o        (ci_idx),
        .snk_valid_o (snk_valid),
        .snk_count_o (snk_count),
        .snk_addr_o  (snk_addr),
        .snk_pool_o  (snk_pool),
        .irq_o       (irq),
        .err_o       (cmd_err)
    );

    always_comb begin
        fill = pi_idx - ci_idx;
        free = (fill >= CAP) ? '0 : (CAP - fill);
    end
endmodule

// File: tb/rcr_vb_consumer_test.sv
module rcr_vb_consumer_test;
    localparam int NB = 8;
    localparam int AW = 16;
    localparam int PW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd2;
    logic ent_we = 1'b0;
    logic [2:0] ent_slot = '0;
    logic [7:0] ent_verb = '0;
    logic [PW-1:0] ent_pool = '0;
    logic [NB*AW-1:0] ent_addr = '0;
    logic [NB*PW-1:0] ent_bpid = '0;
    logic pi_we = 1'b0;
    logic [3:0] pi_wdata = '0;
    logic [3:0] ithresh = '0;
    logic irq_clr = 1'b0;
    logic snk_ready = 1'b0;
    logic snk_valid;
    logic [3:0] snk_count;
    logic [NB*AW-1:0] snk_addr;
    logic [NB*PW-1:0] snk_pool;
    logic [3:0] pi_idx, ci_idx, fill, free;
    logic irq, cmd_err;

    int n_chk = 0;
    int n_err = 0;

    typedef struct packed {
        logic [3:0]       cnt;
        logic [NB*AW-1:0] addr;
        logic [NB*PW-1:0] pool;
    } exp_t;
    exp_t sbq[$];

    rcr_vb_consumer uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .ent_we(ent_we),
        .ent_slot(ent_slot), .ent_verb(ent_verb), .ent_pool(ent_pool),
        .ent_addr(ent_addr), .ent_bpid(ent_bpid), .pi_we(pi_we),
        .pi_wdata(pi_wdata), .ithresh(ithresh), .irq_clr(irq_clr),
        .snk_ready(snk_ready), .snk_valid(snk_valid), .snk_count(snk_count),
        .snk_addr(snk_addr), .snk_pool(snk_pool), .pi_idx(pi_idx),
        .ci_idx(ci_idx), .fill(fill), .free(free), .irq(irq), .cmd_err(cmd_err)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic exp_t mk_exp(input logic [7:0] verb, input logic [PW-1:0] pool,
                                    input logic [NB*AW-1:0] a, input logic [NB*PW-1:0] b);
        exp_t e;
        e.cnt  = verb[3:0];
        e.addr = '0;
        e.pool = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < int'(verb[3:0])) begin
                e.addr[i*AW +: AW] = a[i*AW +: AW];
                e.pool[i*PW +: PW] = (verb[6:4] == 3'd2) ? pool : b[i*PW +: PW];
            end
        end
        return e;
    endfunction

    // driver: writes one slot and records the entry the sink should later see
    task automatic send(input int slot, input logic [7:0] verb, input logic [PW-1:0] pool,
                        input logic [15:0] base, input bit expect_out);
        logic [NB*AW-1:0] a;
        logic [NB*PW-1:0] b;
        for (int i = 0; i < NB; i++) begin
            a[i*AW +: AW] = base + 16'(i * 3);
            b[i*PW +: PW] = 6'(i * 5 + slot + 1);
        end
        if (expect_out) sbq.push_back(mk_exp(verb, pool, a, b));
        ent_slot = 3'(slot);
        ent_verb = verb;
        ent_pool = pool;
        ent_addr = a;
        ent_bpid = b;
        ent_we   = 1'b1;
        tick();
        ent_we   = 1'b0;
    endtask

    task automatic pulse_ready();
        snk_ready = 1'b1;
        tick();
        snk_ready = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // monitor: compares every accepted entry with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && snk_valid && snk_ready) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_err++;
                $display("FAIL R5/R8: unexpected entry count=%0d actual=%h expected=none",
                         snk_count, snk_addr);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (snk_count != e.cnt || snk_addr != e.addr || snk_pool != e.pool) begin
                    n_err++;
                    $display("FAIL R6/R7: actual cnt=%0d addr=%h pool=%h expected cnt=%0d addr=%h pool=%h",
                             snk_count, snk_addr, snk_pool, e.cnt, e.addr, e.pool);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 pi", pi_idx, 0);
        chk("R1 ci", ci_idx, 0);
        chk("R1 fill", fill, 0);
        chk("R1 free", free, 7);
        chk("R1 valid", snk_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 err", cmd_err, 0);

        // R2/R6: single-pool entry, three buffers
        send(0, 8'hA3, 6'h05, 16'h1000, 1'b1);
        tick();
        chk("R2 pi after new slot", pi_idx, 1);
        chk("R3 fill", fill, 1);
        chk("R3 free", free, 6);
        chk("R5 valid", snk_valid, 1);
        chk("R6 count", snk_count, 3);
        snk_ready = 1'b1;
        tick();
        tick();
        snk_ready = 1'b0;
        chk("R5 ci", ci_idx, 1);
        chk("R5 delivered", sbq.size(), 0);
        chk("R10 irq set at zero fill", irq, 1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        chk("R10 irq cleared", irq, 0);

        // R2 stale polarity, then R7 per-buffer pools
        send(1, 8'h32, 6'h11, 16'h1800, 1'b0);
        tick();
        tick();
        chk("R2 stale polarity ignored", pi_idx, 1);
        chk("R2 no offer", snk_valid, 0);
        send(1, 8'hB8, 6'h3F, 16'h2000, 1'b1);
        tick();
        chk("R2 pi after rewrite", pi_idx, 2);
        snk_ready = 1'b1;
        tick();
        tick();
        snk_ready = 1'b0;
        chk("R7 ci", ci_idx, 2);
        chk("R7 delivered", sbq.size(), 0);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        ithresh = 4'd2;

        // R4 fill cap across a wrap
        for (int s = 2; s < 8; s++) begin
            send(s, (s % 2 == 1) ? 8'hB0 | 8'(s + 1) : 8'hA0 | 8'(s + 1),
                 6'(s + 9), 16'(16'h3000 + s * 16'h100), 1'b1);
        end
        send(0, 8'h24, 6'h21, 16'h4000, 1'b1);
        send(1, 8'h35, 6'h22, 16'h4100, 1'b1);
        tick();
        tick();
        chk("R4 pi capped", pi_idx, 9);
        chk("R4 fill", fill, 7);
        chk("R4 free", free, 0);
        for (int p = 0; p < 5; p++) pulse_ready();
        chk("R10 irq not yet", irq, 0);
        chk("R3 pi wrapped with phase", pi_idx, 10);
        pulse_ready();
        chk("R10 irq at threshold", irq, 1);
        irq_clr = 1'b1;
        snk_ready = 1'b1;
        tick();
        irq_clr = 1'b0;
        snk_ready = 1'b0;
        tick();
        chk("R10 set wins over clear", irq, 1);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        chk("R10 clear", irq, 0);
        snk_ready = 1'b1;
        repeat (3) tick();
        snk_ready = 1'b0;
        chk("R3 ci", ci_idx, 10);
        chk("R5 all delivered in order", sbq.size(), 0);

        // R8 malformed verbs, sink ready so forwarding would be seen
        snk_ready = 1'b1;
        send(2, 8'h51, 6'h01, 16'h5000, 1'b0);
        tick();
        tick();
        chk("R8 bad command dropped", ci_idx, 11);
        chk("R8 err set", cmd_err, 1);
        chk("R8 not offered", snk_valid, 0);
        send(3, 8'h20, 6'h01, 16'h5100, 1'b0);
        tick();
        tick();
        chk("R8 zero count dropped", ci_idx, 12);
        send(4, 8'h29, 6'h01, 16'h5200, 1'b0);
        tick();
        tick();
        chk("R8 count nine dropped", ci_idx, 13);
        snk_ready = 1'b0;
        repeat (3) tick();
        chk("R8 err sticky", cmd_err, 1);

        // R9 index producer mode
        cfg_mode = 2'd0;
        send(5, 8'h22, 6'h0C, 16'h6000, 1'b1);
        repeat (3) tick();
        chk("R9 valid bit ignored", pi_idx, 13);
        pi_we = 1'b1;
        pi_wdata = 4'd14;
        tick();
        pi_we = 1'b0;
        chk("R9 pi written", pi_idx, 14);
        chk("R9 offer", snk_valid, 1);
        snk_ready = 1'b1;
        tick();
        tick();
        snk_ready = 1'b0;
        chk("R9 ci", ci_idx, 14);
        chk("R9 delivered", sbq.size(), 0);
        cfg_mode = 2'd2;
        pi_we = 1'b1;
        pi_wdata = 4'd0;
        tick();
        pi_we = 1'b0;
        tick();
        chk("R9 write ignored in valid-bit mode", pi_idx, 14);

        finish_run();
    end
endmodule